// File: doc/BRIEF.md
# I2C status and interrupt register

This block is the status register that sits between an I2C controller's bus engine and the CPU. The engine reports short, one-cycle event strobes: address acknowledged, general call seen, byte finished, STOP seen, addressed as a slave, arbitration lost, and acknowledge sampled. The block latches each strobe into a sticky flag that holds until software clears it. The same byte also shows two live fields, bus busy and transmit direction. Both come straight from the engine.

Five of the sticky flags are interrupt sources. Any of them raises a single interrupt request. Every source except the STOP flag also asserts a clock-hold output, which keeps SCL low until software has cleared all of them. Software clears a flag by writing 0 to its bit. Writing 1 leaves the bit as it was, so one write can acknowledge a chosen subset of flags.

Top module: `i2c_stat_reg`

## Requirements
- R1: Bit layout, MSB to LSB, is: bit 7 address-ack/general-call, bit 6 byte done, bit 5 STOP seen, bit 4 selected as slave, bit 3 arbitration lost, bit 2 bus busy, bit 1 transmitting, bit 0 ack received. While reset is active, and right after it, every sticky bit (7..3 and 0) reads 0, and `irq` and `scl_hold` are 0.
- R2: Bit 7 means different things by role. With `is_master`=1 it is set by `ev_addr_ack`. With `is_master`=0 it is set by `ev_gcall`. The strobe that belongs to the other role has no effect.
- R3: `ev_byte_done`, `ev_stop`, `ev_selected` and `ev_arb_lost` set bits 6, 5, 4 and 3. Each bit reads 1 from the cycle after its strobe and stays 1 until it is cleared.
- R4: `ev_ack` sets bit 0 in the same sticky way. Bit 0 is not an interrupt source.
- R5: Bit 2 always equals `bus_busy` and bit 1 always equals `is_tx` in the same cycle. CPU writes do not change either bit.
- R6: A write with a 0 in sticky bit n clears bit n from the next cycle on. A write with a 1 in bit n leaves bit n unchanged.
- R7: If a set strobe and a clearing write hit the same bit in the same cycle, the bit reads 1 afterwards.
- R8: `irq` is 1 exactly when at least one of bits 7..3 is 1.
- R9: `scl_hold` is 1 exactly when at least one of bits 7, 6, 4 or 3 is 1. Bit 5 set on its own gives `irq`=1 and `scl_hold`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data; a 0 clears the matching sticky bit |
| rd_data | output | 8 | Register read value |
| is_master | input | 1 | Role: 1 master, 0 slave |
| ev_addr_ack | input | 1 | Address acknowledge received (master) |
| ev_gcall | input | 1 | General call address detected (slave) |
| ev_byte_done | input | 1 | One byte transferred |
| ev_stop | input | 1 | STOP condition detected |
| ev_selected | input | 1 | Addressed by another master |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_ack | input | 1 | Acknowledge sampled in ninth clock period |
| bus_busy | input | 1 | Live bus busy state |
| is_tx | input | 1 | Live direction, 1 transmitter |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
A set strobe from the engine and a clearing CPU write can land on the same flag in the same cycle. The bench forces this case on purpose: it drives `ev_byte_done` while writing 00h. It then checks that bit 6 survives while the other flags clear. A long random phase, with sparse events and frequent writes, repeats that collision on every sticky bit in both roles. A behavioural model compares every output on every clock.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_AGC   = 7;
    localparam int BIT_BYTE  = 6;
    localparam int BIT_STOP  = 5;
    localparam int BIT_SEL   = 4;
    localparam int BIT_LOST  = 3;
    localparam int BIT_BUSY  = 2;
    localparam int BIT_TX    = 1;
    localparam int BIT_ACK   = 0;

    localparam logic [REG_W-1:0] STICKY_MASK = 8'hF9;
    localparam logic [REG_W-1:0] IRQ_MASK    = 8'hF8;
    localparam logic [REG_W-1:0] HOLD_MASK   = 8'hD8;

    typedef struct packed {
        logic addr_ack;
        logic gcall;
        logic byte_done;
        logic stop;
        logic selected;
        logic arb_lost;
        logic ack;
    } ev_t;
endpackage

// File: rtl/i2c_stat_evsel.sv
module i2c_stat_evsel
    import i2c_stat_pkg::*;
(
    input  logic             is_master,
    input  ev_t              ev_i,
    output logic [REG_W-1:0] set_o
);
    always_comb begin
        set_o           = '0;
        set_o[BIT_AGC]  = is_master ? ev_i.addr_ack : ev_i.gcall;
        set_o[BIT_BYTE] = ev_i.byte_done;
        set_o[BIT_STOP] = ev_i.stop;
        set_o[BIT_SEL]  = ev_i.selected;
        set_o[BIT_LOST] = ev_i.arb_lost;
        set_o[BIT_ACK]  = ev_i.ack;
    end
endmodule

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: RST_VAL};
        else        st_q <= st_d;
    end

    assign q_o = st_q.flag;
endmodule

// File: rtl/i2c_stat_combine.sv
module i2c_stat_combine #(
    parameter int               W         = 8,
    parameter logic [W-1:0]     IRQ_MASK  = '0,
    parameter logic [W-1:0]     HOLD_MASK = '0
) (
    input  logic [W-1:0] flags_i,
    output logic         irq_o,
    output logic         hold_o
);
    always_comb begin
        irq_o  = |(flags_i & IRQ_MASK);
        hold_o = |(flags_i & HOLD_MASK);
    end
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
    import i2c_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             is_master,
    input  logic             ev_addr_ack,
    input  logic             ev_gcall,
    input  logic             ev_byte_done,
    input  logic             ev_stop,
    input  logic             ev_selected,
    input  logic             ev_arb_lost,
    input  logic             ev_ack,
    input  logic             bus_busy,
    input  logic             is_tx,
    output logic             irq,
    output logic             scl_hold
);
    ev_t              ev;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] sticky_q;

    always_comb begin
        ev.addr_ack  = ev_addr_ack;
        ev.gcall     = ev_gcall;
        ev.byte_done = ev_byte_done;
        ev.stop      = ev_stop;
        ev.selected  = ev_selected;
        ev.arb_lost  = ev_arb_lost;
        ev.ack       = ev_ack;
        clr_vec      = wr_en ? (~wr_data & STICKY_MASK) : '0;
    end

    i2c_stat_evsel u_evsel (
        .is_master (is_master),
        .ev_i      (ev),
        .set_o     (set_vec)
    );

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_sticky
            i2c_stat_flag #(.RST_VAL(1'b0)) u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q_o   (sticky_q[i])
            );
        end else begin : g_live
            assign sticky_q[i] = 1'b0;
        end
    end

    always_comb begin
        rd_data           = sticky_q;
        rd_data[BIT_BUSY] = bus_busy;
        rd_data[BIT_TX]   = is_tx;
    end

    i2c_stat_combine #(
        .W         (REG_W),
        .IRQ_MASK  (IRQ_MASK),
        .HOLD_MASK (HOLD_MASK)
    ) u_comb (
        .flags_i (sticky_q),
        .irq_o   (irq),
        .hold_o  (scl_hold)
    );
endmodule

// File: rtl/i2c_stat_chk.sv
module i2c_stat_chk
    import i2c_stat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             is_master,
    input logic             ev_addr_ack,
    input logic             ev_gcall,
    input logic             ev_byte_done,
    input logic             ev_stop,
    input logic             bus_busy,
    input logic             is_tx,
    input logic             irq,
    input logic             scl_hold
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((rd_data & STICKY_MASK) == '0) && !irq && !scl_hold);
    // R2
    master_aack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_master && ev_addr_ack |=> rd_data[BIT_AGC]);
    // R2
    slave_gcall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master && ev_gcall |=> rd_data[BIT_AGC]);
    // R2
    wrong_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[BIT_AGC] && !(is_master ? ev_addr_ack : ev_gcall) |=> !rd_data[BIT_AGC]);
    // R3
    stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> rd_data[BIT_STOP]);
    // R5
    live_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_BUSY] == bus_busy && rd_data[BIT_TX] == is_tx);
    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_data[BIT_BYTE] && !ev_byte_done |=> !rd_data[BIT_BYTE]);
    // R6
    write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[BIT_BYTE] && !ev_byte_done |=> $stable(rd_data[BIT_BYTE]));
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_data[BIT_BYTE] && ev_byte_done |=> rd_data[BIT_BYTE]);
    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & IRQ_MASK) == '0) |-> !irq);
    // R9
    stop_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_STOP] && ((rd_data & HOLD_MASK) == '0) |-> irq && !scl_hold);
    // R9
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_BYTE] |-> scl_hold && irq);
endmodule

bind i2c_stat_reg i2c_stat_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .is_master    (is_master),
    .ev_addr_ack  (ev_addr_ack),
    .ev_gcall     (ev_gcall),
    .ev_byte_done (ev_byte_done),
    .ev_stop      (ev_stop),
    .bus_busy     (bus_busy),
    .is_tx        (is_tx),
    .irq          (irq),
    .scl_hold     (scl_hold)
);

// File: tb/test_i2c_stat_reg.sv
`timescale 1ns/1ps
module test_i2c_stat_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       is_master = 1'b0;
    logic       ev_addr_ack = 1'b0, ev_gcall = 1'b0, ev_byte_done = 1'b0;
    logic       ev_stop = 1'b0, ev_selected = 1'b0, ev_arb_lost = 1'b0, ev_ack = 1'b0;
    logic       bus_busy = 1'b0, is_tx = 1'b0;
    logic       irq, scl_hold;

    int vec = 0;
    int miss = 0;
    bit [7:0] m = 8'h00;

    always #5 clk = ~clk;

    i2c_stat_reg i_i2c_stat_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .is_master(is_master), .ev_addr_ack(ev_addr_ack), .ev_gcall(ev_gcall),
        .ev_byte_done(ev_byte_done), .ev_stop(ev_stop), .ev_selected(ev_selected),
        .ev_arb_lost(ev_arb_lost), .ev_ack(ev_ack), .bus_busy(bus_busy), .is_tx(is_tx),
        .irq(irq), .scl_hold(scl_hold)
    );

    function automatic void chk(string tag, logic [7:0] act, logic [7:0] exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endfunction

    // ev bits: {addr_ack, gcall, byte_done, stop, selected, arb_lost, ack}
    task automatic step(input bit we, input bit [7:0] wd, input bit mst,
                        input bit [6:0] ev, input bit bsy, input bit tx);
        bit [7:0] setv;
        bit [7:0] clrv;
        wr_en = we; wr_data = wd; is_master = mst;
        {ev_addr_ack, ev_gcall, ev_byte_done, ev_stop, ev_selected, ev_arb_lost, ev_ack} = ev;
        bus_busy = bsy; is_tx = tx;
        #1;
        chk("R2 bit7", {7'd0, rd_data[7]}, {7'd0, m[7]});
        chk("R3 bits6..3", {4'd0, rd_data[6:3]}, {4'd0, m[6:3]});
        chk("R4 bit0", {7'd0, rd_data[0]}, {7'd0, m[0]});
        chk("R5 live", {6'd0, rd_data[2:1]}, {6'd0, bsy, tx});
        chk("R8 irq", {7'd0, irq}, {7'd0, (m[7:3] != 0)});
        chk("R9 hold", {7'd0, scl_hold}, {7'd0, (m[7] | m[6] | m[4] | m[3])});
        setv = 8'h00;
        setv[7] = mst ? ev[6] : ev[5];
        setv[6] = ev[4]; setv[5] = ev[3]; setv[4] = ev[2]; setv[3] = ev[1]; setv[0] = ev[0];
        clrv = 8'h00;
        if (we) for (int i = 0; i < 8; i++) if (i != 1 && i != 2 && !wd[i]) clrv[i] = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (clrv[i]) m[i] = 1'b0;
            if (setv[i]) m[i] = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        miss++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rd", rd_data, 8'h00);
        chk("R1 reset irq/hold", {6'd0, irq, scl_hold}, 8'h00);
        rst_n = 1'b1;
        step(0, 8'hFF, 0, 7'b0, 0, 0);
        chk("R1 after reset", rd_data, 8'h00);
        // R2 master: address ack sets bit 7, general call ignored
        step(0, 8'hFF, 1, 7'b1000000, 0, 0);
        step(0, 8'hFF, 1, 7'b0, 0, 0);
        step(1, 8'h7F, 1, 7'b0, 0, 0);
        step(0, 8'hFF, 1, 7'b0100000, 0, 0);
        step(0, 8'hFF, 1, 7'b0, 0, 0);
        chk("R2 gcall ignored in master", {7'd0, rd_data[7]}, 8'h00);
        // R2 slave: general call sets, address ack ignored
        step(0, 8'hFF, 0, 7'b1000000, 0, 0);
        step(0, 8'hFF, 0, 7'b0, 0, 0);
        chk("R2 aack ignored in slave", {7'd0, rd_data[7]}, 8'h00);
        step(0, 8'hFF, 0, 7'b0100000, 0, 0);
        step(1, 8'h00, 0, 7'b0, 0, 0);
        // R9 STOP alone: irq without hold
        step(0, 8'hFF, 0, 7'b0001000, 1, 0);
        step(0, 8'hFF, 0, 7'b0, 1, 0);
        chk("R9 stop no hold", {6'd0, irq, scl_hold}, 8'h02);
        // R7 set wins over clear
        step(0, 8'hFF, 0, 7'b0000111, 0, 1);
        step(1, 8'h00, 0, 7'b0010000, 0, 1);
        chk("R7 set wins", rd_data, 8'h42);
        // R6 write ones keeps, write zero clears
        step(1, 8'hFF, 0, 7'b0, 1, 1);
        chk("R6 write one keeps", rd_data, 8'h46);
        step(1, 8'hBF, 0, 7'b0, 1, 1);
        chk("R6 write zero clears", rd_data, 8'h06);
        // R5 writes to live bits ignored, R4 ack not an interrupt
        step(1, 8'hF9, 0, 7'b0000001, 1, 0);
        step(1, 8'h06, 0, 7'b0, 1, 0);
        chk("R4 ack no irq", {6'd0, irq, scl_hold}, 8'h00);
        step(1, 8'h00, 1, 7'b0, 0, 1);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit [6:0] ev;
            for (int k = 0; k < 7; k++) ev[k] = ($urandom % 12) == 0;
            step(($urandom % 4) == 0, 8'($urandom), 1'($urandom), ev,
                 1'($urandom), 1'($urandom));
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end
endmodule